// File: doc/BRIEF.md
# Gated UART Transmitter

This block serializes bytes onto an asynchronous serial line. Software places a byte into a one-entry holding register, and an internal shift engine takes it from there. Each frame is one low start bit, then the data bits with the least significant bit first, then an optional parity bit of odd or even sense, then one or two high stop bits. The line rests high between frames. Every bit lasts exactly one period of an external baud tick. Frames start only on a tick edge, so every bit cell, the start bit included, has the same length.

The holding register is protected by a handshake. A write into it is taken only if a status read came after the previous write. The status read sets a single armed bit, and the next write uses it up whether or not that write is taken. A taken write clears the buffer-empty flag. When the engine pulls the byte in, the flag is set again and the interrupt output pulses for one clock. While transmit is disabled, the line stays high. After transmit is enabled, the line stays high until the first byte is taken. If transmit is disabled during a frame, that frame runs to its end and the engine then holds. A byte already waiting in the holding register stays there until transmit is enabled again.

Top module: `uart_tx_gated`

## Requirements
- R1: After reset, txd is 1, buf_empty is 1 and tx_irq is 0.
- R2: While tx_en is 0 and no frame is running, txd stays 1. After tx_en rises, txd stays 1 until a byte has been taken.
- R3: buf_wr is taken only when all of these hold: stat_rd has pulsed since the previous buf_wr, tx_en is 1, and buf_empty is 1. Every buf_wr uses up the armed state. A write that is not taken leaves buf_empty at 1, and no frame is sent for it.
- R4: buf_empty reads 0 in the cycle after a taken write.
- R5: A held byte moves into the shifter on a clock edge where baud_tick is 1 and the shifter is idle or is sending its last bit. From that edge on, buf_empty is 1, and tx_irq is 1 for exactly one cycle. There is one pulse per byte sent.
- R6: txd changes only on edges where baud_tick is 1. A frame begins with a start bit at 0 that lasts one tick interval. Data bit 0 follows, then the remaining data bits in order up to bit 7.
- R7: With par_en set, a parity bit follows the data. With par_odd at 0, the total count of ones over the data bits and the parity bit is even. With par_odd at 1, that count is odd.
- R8: The frame ends with stop bits at 1: one when stop_two is 0, two when stop_two is 1. par_en, par_odd and stop_two are captured when the byte enters the shifter.
- R9: If tx_en falls during a frame, that frame completes. After it, txd stays 1 and a byte already held stays held with buf_empty at 0. That byte is sent once tx_en returns to 1.
- R10: If a byte is held when a frame's last stop bit ends, the next start bit follows in the very next tick interval, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable |
| par_en | input | 1 | Add a parity bit |
| par_odd | input | 1 | Parity sense: 1 selects odd, 0 selects even |
| stop_two | input | 1 | 1 selects two stop bits, 0 selects one |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| stat_rd | input | 1 | Status read strobe; sets the armed state |
| buf_wr | input | 1 | Holding-register write strobe |
| buf_wdata | input | 8 | Byte to send |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding register can accept a byte |
| tx_irq | output | 1 | One-cycle pulse when a byte enters the shifter |

## Verification
Random bytes are sent under every combination of parity on or off, parity sense and stop count. A decoder in the bench catches bit-order, parity-sense and stop-count faults. Some of these random frames are queued back to back. A stray extra stop bit or an idle gap then shows up as a late start bit, which a frame in isolation would hide. Directed cases try a write with no prior read, a second write on a single read, and a read and write while disabled; each of these should move neither the flag nor the line. Another directed case disables transmit during a frame with a byte already held. It separates "finish the frame and hold the byte" from "drop the byte" and from "keep sending".

// File: rtl/uart_txg_pkg.sv
package uart_txg_pkg;
   // frame options captured when a byte enters the shifter
   typedef struct packed {
      logic par_en;
      logic par_odd;
      logic stop_two;
   } txg_cfg_t;
endpackage

// File: rtl/txg_gate.sv
module txg_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic stat_rd,
   input  logic buf_wr,
   input  logic tx_en,
   input  logic buf_empty,
   output logic accept,
   output logic arm_q
);
   // write is judged against the armed state from before this cycle
   assign accept = buf_wr & arm_q & tx_en & buf_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       arm_q <= 1'b0;
      else if (stat_rd) arm_q <= 1'b1;
      else if (buf_wr)  arm_q <= 1'b0;
   end
endmodule

// File: rtl/txg_hold.sv
module txg_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [DATA_W-1:0] wdata,
   input  logic              load,
   output logic [DATA_W-1:0] hold_data,
   output logic              full,
   output logic              irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_data <= '0;
         full      <= 1'b0;
         irq       <= 1'b0;
      end else begin
         irq <= load;
         if (accept) begin
            hold_data <= wdata;
            full      <= 1'b1;
         end else if (load) begin
            full <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/txg_framer.sv
module txg_framer
   import uart_txg_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit HAS_PARITY = 1'b1,
   parameter int STOP_MAX   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              load_req,
   input  logic [DATA_W-1:0] data,
   input  txg_cfg_t          cfg,
   output logic              load,
   output logic              txd,
   output logic              busy
);
   localparam int FRAME_W = DATA_W + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   logic [FRAME_W-1:0] sr_q, frame_d;
   logic [CNT_W-1:0]   left_q, len_d;
   logic               busy_q, last, use_par, use_two, par_bit;

   generate
      if (HAS_PARITY) begin : g_par
         assign use_par = cfg.par_en;
         assign par_bit = (^data) ^ cfg.par_odd;
      end else begin : g_nopar
         assign use_par = 1'b0;
         assign par_bit = 1'b0;
      end
      if (STOP_MAX >= 2) begin : g_two
         assign use_two = cfg.stop_two;
      end else begin : g_one
         assign use_two = 1'b0;
      end
   endgenerate

   always_comb begin
      frame_d           = '1;
      frame_d[0]        = 1'b0;
      frame_d[DATA_W:1] = data;
      if (use_par) frame_d[DATA_W+1] = par_bit;
      len_d = CNT_W'(DATA_W + 2) + CNT_W'(use_par) + CNT_W'(use_two);
   end

   assign last = (left_q == CNT_W'(1));
   assign load = baud_tick & load_req & (~busy_q | last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '1;
         left_q <= '0;
         busy_q <= 1'b0;
      end else if (baud_tick) begin
         if (load) begin
            sr_q   <= frame_d;
            left_q <= len_d;
            busy_q <= 1'b1;
         end else if (busy_q) begin
            sr_q   <= {1'b1, sr_q[FRAME_W-1:1]};
            left_q <= left_q - CNT_W'(1);
            busy_q <= ~last;
         end
      end
   end

   assign txd  = busy_q ? sr_q[0] : 1'b1;
   assign busy = busy_q;
endmodule

// File: rtl/uart_tx_gated.sv
module uart_tx_gated
   import uart_txg_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit HAS_PARITY = 1'b1,
   parameter int STOP_MAX   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              stop_two,
   input  logic              baud_tick,
   input  logic              stat_rd,
   input  logic              buf_wr,
   input  logic [DATA_W-1:0] buf_wdata,
   output logic              txd,
   output logic              buf_empty,
   output logic              tx_irq
);
   generate
      if (DATA_W < 5 || DATA_W > 16) begin : g_bad_w
         $error("uart_tx_gated: DATA_W must lie in 5..16");
      end
      if (STOP_MAX < 1 || STOP_MAX > 2) begin : g_bad_s
         $error("uart_tx_gated: STOP_MAX must be 1 or 2");
      end
   endgenerate

   logic              accept, arm_q, hold_full, load, frm_busy;
   logic [DATA_W-1:0] hold_data;
   txg_cfg_t          cfg;

   assign cfg       = '{par_en: par_en, par_odd: par_odd, stop_two: stop_two};
   assign buf_empty = ~hold_full;

   txg_gate u_gate (
      .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .buf_wr(buf_wr),
      .tx_en(tx_en), .buf_empty(buf_empty), .accept(accept), .arm_q(arm_q)
   );

   txg_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .accept(accept), .wdata(buf_wdata),
      .load(load), .hold_data(hold_data), .full(hold_full), .irq(tx_irq)
   );

   txg_framer #(.DATA_W(DATA_W), .HAS_PARITY(HAS_PARITY), .STOP_MAX(STOP_MAX)) u_frm (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .load_req(hold_full & tx_en), .data(hold_data), .cfg(cfg),
      .load(load), .txd(txd), .busy(frm_busy)
   );
endmodule

// File: rtl/txg_checker.sv
module txg_checker (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic baud_tick,
   input logic buf_wr,
   input logic txd,
   input logic buf_empty,
   input logic tx_irq,
   input logic armed,
   input logic busy
);
   assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !busy) |=> txd);
   assert_unarmed_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_wr && !armed && buf_empty) |=> buf_empty);
   assert_taken_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_wr && armed && tx_en && buf_empty) |=> !buf_empty);
   assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |=> !tx_irq);
   assert_irq_with_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> buf_empty);
   assert_line_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_tick |=> $stable(txd));
   assert_ends_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(txd));
endmodule

bind uart_tx_gated txg_checker u_chk (
   .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_tick(baud_tick),
   .buf_wr(buf_wr), .txd(txd), .buf_empty(buf_empty), .tx_irq(tx_irq),
   .armed(arm_q), .busy(frm_busy)
);

// File: tb/sim_uart_tx_gated.sv
module sim_uart_tx_gated;
   localparam int TICKP = 5;

   typedef struct {
      logic [7:0] d;
      bit pe, od, two, btb;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0, stop_two = 1'b0;
   logic baud_tick = 1'b0, stat_rd = 1'b0, buf_wr = 1'b0;
   logic [7:0] buf_wdata = '0;
   logic txd, buf_empty, tx_irq;

   int checks = 0, errors = 0;
   int accepted = 0, irq_cnt = 0, frames_done = 0;
   int tick_no = 0, last_end = -10;
   bit tick_fired = 1'b0, irq_prev = 1'b0, in_frame = 1'b0;
   int idx = 0, nbits = 0;
   logic [11:0] bits;
   exp_t cur;
   exp_t exp_q[$];

   always #2 clk = ~clk;

   uart_tx_gated u0 (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .par_en(par_en),
      .par_odd(par_odd), .stop_two(stop_two), .baud_tick(baud_tick),
      .stat_rd(stat_rd), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
      .txd(txd), .buf_empty(buf_empty), .tx_irq(tx_irq)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit exp_par(input logic [7:0] d, input bit odd);
      return (^d) ^ odd;
   endfunction

   initial begin
      forever begin
         repeat (TICKP - 1) @(negedge clk);
         baud_tick = 1'b1;
         @(negedge clk);
         baud_tick = 1'b0;
      end
   end

   always @(posedge clk) tick_fired <= baud_tick;

   // frame decoder: samples the line right after each tick edge
   always @(negedge clk) begin
      if (rst_n && tick_fired) begin
         tick_no++;
         if (!in_frame) begin
            if (txd == 1'b0) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R3", "unexpected frame start", 1, 0);
               end else begin
                  cur = exp_q.pop_front();
                  in_frame = 1'b1;
                  idx = 0;
                  nbits = 8 + int'(cur.pe) + 1 + int'(cur.two);
                  if (cur.btb) chk(tick_no == last_end + 1, "R10", "gap before start", tick_no, last_end + 1);
               end
            end
         end else begin
            bits[idx] = txd;
            idx++;
            if (idx == nbits) begin
               chk(bits[7:0] == cur.d, "R6", "data bits", int'(bits[7:0]), int'(cur.d));
               if (cur.pe) chk(bits[8] == exp_par(cur.d, cur.od), "R7", "parity bit",
                               int'(bits[8]), int'(exp_par(cur.d, cur.od)));
               chk(bits[nbits-1] == 1'b1, "R8", "last stop bit", int'(bits[nbits-1]), 1);
               if (cur.two) chk(bits[nbits-2] == 1'b1, "R8", "first stop bit", int'(bits[nbits-2]), 1);
               in_frame = 1'b0;
               last_end = tick_no;
               frames_done++;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_irq) begin
            irq_cnt++;
            chk(buf_empty == 1'b1, "R5", "flag at irq", int'(buf_empty), 1);
         end
         if (tx_irq && irq_prev) chk(1'b0, "R5", "irq longer than one cycle", 2, 1);
         irq_prev = tx_irq;
      end
   end

   task automatic do_read();
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
   endtask

   task automatic do_write(input logic [7:0] d);
      buf_wr = 1'b1;
      buf_wdata = d;
      @(negedge clk);
      buf_wr = 1'b0;
   endtask

   task automatic send(input logic [7:0] d, input bit pe, input bit od,
                       input bit two, input bit btb);
      exp_t e;
      while (!buf_empty) @(negedge clk);
      par_en = pe; par_odd = od; stop_two = two;
      do_read();
      do_write(d);
      chk(buf_empty == 1'b0, "R4", "flag after taken write", int'(buf_empty), 0);
      e.d = d; e.pe = pe; e.od = od; e.two = two; e.btb = btb;
      exp_q.push_back(e);
      accepted++;
      while (!tx_irq) @(negedge clk);
   endtask

   task automatic line_high(input int n, input string req);
      int lows = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (txd !== 1'b1) lows++;
      end
      chk(lows == 0, req, "cycles with line low", lows, 0);
   endtask

   initial begin
      int irq0, fd0;
      void'($urandom(32'h1ce5eed));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
      chk(buf_empty == 1'b1, "R1", "buf_empty after reset", int'(buf_empty), 1);
      chk(tx_irq == 1'b0, "R1", "tx_irq after reset", int'(tx_irq), 0);

      // disabled: read+write is refused, line stays high (R2, R3)
      line_high(20, "R2");
      do_read();
      do_write(8'hA5);
      chk(buf_empty == 1'b1, "R3", "write while disabled", int'(buf_empty), 1);
      tx_en = 1'b1;
      irq0 = irq_cnt;
      line_high(40, "R2");
      chk(irq_cnt == irq0, "R2", "irq count after enable", irq_cnt, irq0);

      // write with no status read first (R3)
      do_write(8'h3C);
      chk(buf_empty == 1'b1, "R3", "write without read", int'(buf_empty), 1);
      line_high(40, "R3");

      // directed frames
      send(8'h01, 1'b0, 1'b0, 1'b0, 1'b0);
      send(8'h80, 1'b1, 1'b0, 1'b1, 1'b1);
      send(8'hFF, 1'b1, 1'b1, 1'b0, 1'b1);
      send(8'h00, 1'b0, 1'b0, 1'b0, 1'b1);

      // a second write on the same read is refused (R3)
      do_write(8'h77);
      chk(buf_empty == 1'b1, "R3", "second write on one read", int'(buf_empty), 1);

      // disable during a frame with a byte held (R9)
      send(8'h5A, 1'b1, 1'b0, 1'b0, 1'b0);
      fd0 = frames_done;
      do_read();
      do_write(8'hC3);
      begin
         exp_t e;
         e.d = 8'hC3; e.pe = 1'b1; e.od = 1'b0; e.two = 1'b0; e.btb = 1'b0;
         exp_q.push_back(e);
      end
      accepted++;
      @(negedge clk);
      tx_en = 1'b0;
      while (frames_done == fd0) @(negedge clk);
      line_high(TICKP * 12, "R9");
      chk(buf_empty == 1'b0, "R9", "held byte kept while disabled", int'(buf_empty), 0);
      chk(frames_done == fd0 + 1, "R9", "frames while disabled", frames_done, fd0 + 1);
      tx_en = 1'b1;
      while (!tx_irq) @(negedge clk);

      // random frames, some queued back to back
      for (int i = 0; i < 30; i++) begin
         logic [7:0] d;
         bit pe, od, two, btb;
         d   = 8'($urandom);
         pe  = 1'($urandom);
         od  = 1'($urandom);
         two = 1'($urandom);
         btb = 1'($urandom);
         if (!btb) begin
            while (in_frame || exp_q.size() != 0) @(negedge clk);
            repeat (int'($urandom_range(0, 12))) @(negedge clk);
         end
         send(d, pe, od, two, btb);
      end

      while (in_frame || exp_q.size() != 0) @(negedge clk);
      repeat (TICKP * 3) @(negedge clk);
      chk(irq_cnt == accepted, "R5", "irq pulses per byte", irq_cnt, accepted);
      chk(frames_done == accepted, "R6", "frames decoded", frames_done, accepted);
      chk(txd == 1'b1, "R2", "line idle at end", int'(txd), 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule